// File: doc/BRIEF.md
# Programmable Watchdog Timer with Power-Down Handling

This block is the watchdog of a small microcontroller core. A prescaler divides the oscillator clock into machine-cycle ticks. A counter advances on each tick. Software picks one of eight timeouts through a 3-bit selector. Each timeout is a power of two minus one, counted in machine cycles. If software does not service the counter before it reaches that terminal count, the block drives a device reset request for a fixed number of oscillator cycles and then disables itself.

The watchdog starts disabled. Software arms it, and later services it, by writing two fixed byte values to the service register in two consecutive writes. Every valid service sequence clears the counter and loads the selected timeout. In power-down the oscillator is stopped, so the counter holds its value and cannot fire. A hardware reset taken during power-down leaves the watchdog disabled. Power-down can also end through the active-low external wake pin. In that case counting stays held off for as long as the pin is still low after power-down ends.

Top module: `wdt_core`

## Requirements
- R1: After reset, `wdt_rst_req`, `stat_armed` and `stat_hold` are 0 and `stat_sel` reads 0.
- R2: A write of KEY_A (default 8'h1E) to the service register (`wr_sel`=1) followed directly by a write of KEY_B (default 8'hE1) to the same register arms the watchdog. It also clears the counter and the prescaler, so a sequence issued while the watchdog is armed restarts the full timeout.
- R3: Any other pattern does not arm and does not restart the count. This covers KEY_B without a KEY_A directly before it, a different byte, or any write placed between the two keys.
- R4: A write with `wr_sel`=0 stores `wr_data[SEL_W-1:0]` as the selector S, which reads back on `stat_sel`. A new S only takes effect at the next valid service sequence.
- R5: With no freezing, `wdt_rst_req` rises exactly (2^(BASE_EXP+S)-1)·DIV clock edges after the edge that captures KEY_B.
- R6: `wdt_rst_req` stays high for exactly RST_LEN cycles. `stat_armed` is 0 once the request falls, and no further request follows.
- R7: While `pdown` is 1, the counter and the prescaler hold their values. Each clock spent in power-down delays the expiry by exactly one cycle.
- R8: A reset taken during power-down leaves the watchdog disarmed, with the selector cleared and no request afterwards.
- R9: Power-down may end while `wake_n` is still low. Counting then stays held, with `stat_hold`=1, until `wake_n` goes high. Each held cycle delays the expiry by one cycle. If `wake_n` is low without a prior power-down, counting is not held.
- R10: While the watchdog is disarmed, `wdt_rst_req` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: selector register, 1: service register |
| wr_data | input | DATA_W | Write data |
| pdown | input | 1 | Power-down state (oscillator stopped) |
| wake_n | input | 1 | Active-low external wake interrupt pin |
| wdt_rst_req | output | 1 | Device reset request |
| stat_armed | output | 1 | Watchdog is armed |
| stat_sel | output | SEL_W | Selector register readback |
| stat_hold | output | 1 | Counting held after an interrupt wake |

## Verification
A counter that is reloaded wrongly, or not frozen, shows up directly as a shift in the edge on which `wdt_rst_req` rises. The bench measures that edge against the timeout and freeze intervals it computes itself, so a single lost or extra machine cycle appears one to DIV cycles away from the expected edge. A wrong pulse counter or a wrong arming state shows up within RST_LEN cycles as a bad pulse width, a `stat_armed` that stays set, or a request in a window that should stay quiet.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // terminal count for selector value sel: 2^(base_exp+sel) - 1
  function automatic logic [31:0] wdt_limit(input int base_exp, input int sel);
    return (32'd1 << (base_exp + sel)) - 32'd1;
  endfunction

  // counter width needed to reach the largest terminal count
  function automatic int wdt_cnt_width(input int base_exp, input int sel_w);
    return base_exp + (1 << sel_w) - 1;
  endfunction
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q;

  assign tick = run && (ph_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ph_q <= '0;
    else if (clr) ph_q <= '0;
    else if (run) ph_q <= (ph_q == LAST) ? '0 : ph_q + PW'(1);
  end
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fire
);
  logic pend_q;
  logic svc_wr;

  assign svc_wr = wr_en && wr_sel;
  assign fire   = svc_wr && pend_q && (wr_data == KEY_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (svc_wr) pend_q <= (wr_data == KEY_A);
    else if (wr_en)  pend_q <= 1'b0;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int BASE_EXP = 14,
  parameter int SEL_W    = 3,
  parameter int CNT_W    = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [SEL_W-1:0] sel_new,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] lim,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, lim_q, lim_d;

  assign lim_d  = CNT_W'(wdt_pkg::wdt_limit(BASE_EXP, int'(sel_new)));
  assign expire = run && tick && (cnt_q == lim_q - CNT_W'(1));
  assign cnt    = cnt_q;
  assign lim    = lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= CNT_W'(wdt_pkg::wdt_limit(BASE_EXP, 0));
    end else if (reload) begin
      cnt_q <= '0;
      lim_q <= lim_d;
    end else if (expire) begin
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int DIV      = 12,
  parameter int BASE_EXP = 14,
  parameter int SEL_W    = 3,
  parameter int DATA_W   = 8,
  parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1,
  parameter int RST_LEN  = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pdown,
  input  logic              wake_n,
  output logic              wdt_rst_req,
  output logic              stat_armed,
  output logic [SEL_W-1:0]  stat_sel,
  output logic              stat_hold
);
  localparam int CNT_W = wdt_pkg::wdt_cnt_width(BASE_EXP, SEL_W);
  localparam int PLW   = $clog2(RST_LEN + 1);

  // internal events, named for the checker
  logic             fire, tick, run, expire, hold_eff, pulse_on, pulse_end;
  logic [CNT_W-1:0] cnt, lim;
  logic [SEL_W-1:0] sel_q;
  logic             armed_q, hold_q;
  logic [PLW-1:0]   pulse_q;

  wdt_key_seq #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .fire(fire)
  );

  wdt_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(fire), .run(run), .tick(tick)
  );

  wdt_counter #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .reload(fire), .sel_new(sel_q),
    .run(run), .tick(tick), .cnt(cnt), .lim(lim), .expire(expire)
  );

  assign hold_eff  = hold_q && !wake_n;
  assign pulse_on  = (pulse_q != '0);
  assign pulse_end = (pulse_q == PLW'(1));
  assign run       = armed_q && !pdown && !hold_eff && !pulse_on;

  // selector register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sel_q <= '0;
    else if (wr_en && !wr_sel) sel_q <= wr_data[SEL_W-1:0];
  end

  // wake hold: set while powered down with the pin low, cleared by the pin rising
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= 1'b0;
    else if (wake_n) hold_q <= 1'b0;
    else if (pdown)  hold_q <= 1'b1;
  end

  // reset request pulse and arming
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (expire)        pulse_q <= PLW'(RST_LEN);
      else if (pulse_on) pulse_q <= pulse_q - PLW'(1);
      if (pulse_end)     armed_q <= 1'b0;
      else if (fire)     armed_q <= 1'b1;
    end
  end

  assign wdt_rst_req = pulse_on;
  assign stat_armed  = armed_q;
  assign stat_sel    = sel_q;
  assign stat_hold   = hold_eff;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pdown,
  input logic             fire,
  input logic             hold_eff,
  input logic             run,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lim,
  input logic             wdt_rst_req,
  input logic             stat_armed
);
  // R2: a valid service sequence leaves the counter at zero
  a_r2_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == '0));

  // R5: the request only starts from a tick at the terminal count
  a_r5_fire_at_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_req) |-> ($past(cnt) == $past(lim) - CNT_W'(1)) && $past(run) && $past(tick));

  // R6: the watchdog is disarmed once the request ends
  a_r6_disarm_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_req) |-> !stat_armed);

  // R7: frozen in power-down
  a_r7_frozen_pdown: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown && !fire) |=> $stable(cnt));

  // R9: held after an interrupt wake while the pin is low
  a_r9_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_eff && !fire) |=> $stable(cnt));

  // R10: no request while disarmed
  a_r10_quiet_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_armed && !wdt_rst_req) |=> !wdt_rst_req);
endmodule

bind wdt_core wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pdown(pdown), .fire(fire), .hold_eff(hold_eff),
  .run(run), .tick(tick), .cnt(cnt), .lim(lim),
  .wdt_rst_req(wdt_rst_req), .stat_armed(stat_armed)
);

// File: tb/tb_wdt_core.sv
`timescale 1ns/1ps
module tb_wdt_core;
  localparam int DIV = 3;
  localparam int BASE = 4;
  localparam int RLEN = 8;
  localparam logic [7:0] KA = 8'h1E;
  localparam logic [7:0] KB = 8'hE1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic pdown = 1'b0, wake_n = 1'b1;
  logic wdt_rst_req, stat_armed, stat_hold;
  logic [2:0] stat_sel;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  wdt_core #(.DIV(DIV), .BASE_EXP(BASE), .SEL_W(3), .DATA_W(8),
             .KEY_A(KA), .KEY_B(KB), .RST_LEN(RLEN)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pdown(pdown), .wake_n(wake_n), .wdt_rst_req(wdt_rst_req),
    .stat_armed(stat_armed), .stat_sel(stat_sel), .stat_hold(stat_hold)
  );

  function automatic int period(input int sel);
    return ((1 << (BASE + sel)) - 1) * DIV;
  endfunction

  function automatic int exp_edges(input int sel, input int fl, input int hl);
    return period(sel) + fl + ((fl > 0) ? hl : 0);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_prog(input int sel);
    wr(1'b0, 8'(sel));
    check("R4 selector readback", stat_sel, sel);
  endtask

  // ends at the negedge after the edge that captured KEY_B
  task automatic do_service();
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b1; wr_data = KA;
    @(negedge clk); wr_data = KB;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic quiet(input int cycles, input string req);
    int rises = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (wdt_rst_req) rises++;
    end
    check(req, rises, 0);
  endtask

  // one armed period with optional freeze, wake hold and one non-servicing write
  task automatic run_case(input int sel, input int fs, input int fl, input int hl,
                          input int jw, input int jk, input logic [7:0] jd);
    int n = 0;
    int m;
    int expn;
    set_prog(sel);
    do_service();
    expn = exp_edges(sel, fl, hl);
    while (!wdt_rst_req && n < expn + 40) begin
      if (n == fs + fl) check("R9 hold status", stat_hold, (fl > 0) ? 1 : 0);
      pdown  = (n >= fs && n < fs + fl);
      wake_n = !(n >= fs && n < fs + fl + hl);
      if (n == jw) begin
        wr_en = 1'b1;
        wr_sel = (jk != 0);
        wr_data = (jk == 1) ? KA : (jk == 3) ? KB : jd;
      end else begin
        wr_en = 1'b0;
      end
      @(posedge clk); n++; @(negedge clk);
    end
    wr_en = 1'b0; pdown = 1'b0; wake_n = 1'b1;
    check("R5/R7/R9/R3 expiry edge", n, expn);
    m = 0;
    while (wdt_rst_req && m < RLEN + 20) begin
      m++; @(negedge clk);
    end
    check("R6 pulse length", m, RLEN);
    check("R6 disarmed after pulse", stat_armed, 0);
    quiet(60, "R10 no request after disarm");
  endtask

  initial begin
    #1500000;
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 request", wdt_rst_req, 0);
    check("R1 armed", stat_armed, 0);
    check("R1 selector", stat_sel, 0);
    check("R1 hold", stat_hold, 0);
    rst_n = 1'b1;
    quiet(80, "R10 disarmed after reset");

    // R2/R5 smallest and largest timeouts
    run_case(0, 0, 0, 0, -1, 0, 8'h00);
    run_case(7, 0, 0, 0, -1, 0, 8'h00);
    // R4 selector change mid-period, R7 freeze and R9 wake hold
    run_case(2, 10, 30, 25, 5, 0, 8'h05);
    // R9 pin low without power-down does not hold; lone KEY_A does not reload (R3)
    run_case(1, 5, 0, 20, 8, 1, 8'h00);
    // R3 lone KEY_B does not reload
    run_case(1, 3, 12, 0, 4, 3, 8'h00);

    // R2 restart while armed: counting for 30 cycles, then reloaded
    set_prog(1);
    do_service();
    repeat (30) @(negedge clk);
    check("R2 armed", stat_armed, 1);
    run_case(1, 0, 0, 0, -1, 0, 8'h00);

    // R3 broken sequences while disarmed
    wr(1'b1, KA); wr(1'b0, 8'h00); wr(1'b1, KB);
    check("R3 interleaved write", stat_armed, 0);
    wr(1'b1, KA); wr(1'b1, 8'h55); wr(1'b1, KB);
    check("R3 wrong byte", stat_armed, 0);
    wr(1'b1, KB);
    check("R3 KEY_B alone", stat_armed, 0);
    quiet(100, "R10 broken sequences");

    // R8 reset during power-down
    set_prog(3);
    do_service();
    repeat (10) @(negedge clk);
    pdown = 1'b1; wake_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pdown = 1'b0; wake_n = 1'b1;
    @(negedge clk);
    check("R8 armed", stat_armed, 0);
    check("R8 selector", stat_sel, 0);
    check("R8 hold", stat_hold, 0);
    quiet(period(3) + 50, "R8 no request");

    // random cases
    for (int k = 0; k < 8; k++) begin
      int s  = $urandom_range(0, 4);
      int fs = $urandom_range(0, 10);
      int fl = $urandom_range(0, 20);
      int hl = $urandom_range(0, 20);
      int jw = $urandom_range(1, 30);
      int jk = $urandom_range(0, 3);
      logic [7:0] jd = 8'($urandom_range(0, 255));
      run_case(s, fs, fl, hl, jw, jk, jd);
    end

    summary();
    $finish;
  end
endmodule